// File: doc/BRIEF.md
# PLL Output Clock Gate Controller

This block decides when a PLL's raw output clock may be passed on to the logic downstream of it. It produces a registered gate-enable level and a lock status flag. It sequences the PLL from switch-on, through a start-up wait and a qualification phase, into steady running. After the gate has opened for the first time, a separate policy decides whether a later loss of lock closes the gate again.

Configuration selects one of three ways to qualify the first opening of the gate:

- **Lock-wait:** wait for the raw lock signal, brought in through a synchronizer.
- **Timer:** wait for a fixed countdown of 16 reference cycles per unit of the lock-time field, whatever the raw lock signal does.
- **Fast:** open as soon as start-up is reported, while frequency acquisition is still in progress.

The block samples its configuration once, when it is switched on, and holds it until it is switched off again.

All pins are plain control and status levels. There is no data stream, so no valid/ready handshake applies. The outputs change only on rising edges of the reference clock.

Top module: `pll_gate_ctrl`

## Requirements
- R1: During and after reset, and whenever the block is off, `gate_en_o` and `lock_flag_o` are 0. `gate_en_o` is 1 only while the block is running.
- R2: One edge after `enable_i` is sampled low, `gate_en_o` and `lock_flag_o` are 0 and the lock timer is cleared. A later re-enable therefore goes through the full start-up and qualification sequence again.
- R3: After enable, the gate stays closed and the lock flag stays 0 while `startup_done_i` is low.
- R4: With fast wake-up selected (`fast_wake_i`=1), the gate opens on the edge that first samples `startup_done_i` high, and `lock_steps_i` is ignored. The lock flag at that edge equals the synchronized raw lock.
- R5: With lock-wait policy (`fast_wake_i`=0, `lock_steps_i`=0), the gate and the lock flag rise together on the edge after the synchronized lock is seen high. The synchronizer has two stages, so the gate rises on the third edge after `pll_lock_i` rises. If the lock is already synchronized, the gate rises one edge after `startup_done_i` is sampled.
- R6: With timer policy (`fast_wake_i`=0, `lock_steps_i`=L≠0), the gate and the lock flag rise exactly 16·L+1 edges after the edge that samples `startup_done_i` high, whatever `pll_lock_i` does.
- R7: While running with `lock_bypass_i`=0 and after first acquisition, the lock flag follows the synchronized raw lock. The gate closes on the third edge after `pll_lock_i` falls, and reopens on the third edge after it rises.
- R8: While running with `lock_bypass_i`=1, the gate stays open whatever `pll_lock_i` does. The lock flag still follows the synchronized raw lock.
- R9: With fast wake-up, the gate stays open until the synchronized lock is first seen high while running (first acquisition). After that, R7 or R8 applies.
- R10: `lock_steps_i`, `fast_wake_i` and `lock_bypass_i` are captured on the edge where `enable_i` is first seen high. Changes made to them afterwards have no effect until the next enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Switch-on level; low forces the block off |
| pll_lock_i | input | 1 | Raw, asynchronous PLL lock indication |
| startup_done_i | input | 1 | PLL start-up time has elapsed |
| lock_steps_i | input | LT_W | Lock-time field; 0 selects lock-wait, nonzero selects timer |
| fast_wake_i | input | 1 | Selects the fast wake-up policy |
| lock_bypass_i | input | 1 | After first acquisition, keep the gate open regardless of lock |
| gate_en_o | output | 1 | Registered enable for the output clock gate |
| lock_flag_o | output | 1 | Lock status flag |

## Verification
The three qualification policies are each driven with the raw lock held high and held low. The point is to show that only the lock-wait policy waits on the lock signal, while the timer and fast policies open at their own fixed instants. Edges are counted exactly on both sides of the opening, so a countdown that is one cycle off, or a synchronizer with the wrong depth, shows up as a mismatch. After opening, lock is dropped and restored with bypass on and off, and before and after first acquisition in fast mode, to tell the two post-opening policies apart. The configuration inputs are changed while the block is qualifying and while it is running, to show that only the values captured at enable count.

// File: rtl/pgc_pkg.sv
`timescale 1ns/1ps
package pgc_pkg;
  typedef enum logic [1:0] {
    PGC_OFF     = 2'd0,
    PGC_STARTUP = 2'd1,
    PGC_QUALIFY = 2'd2,
    PGC_RUNNING = 2'd3
  } pgc_state_e;

  // first-opening qualification policy, decoded once at enable
  typedef enum logic [1:0] {
    POL_LOCK  = 2'd0,
    POL_TIMER = 2'd1,
    POL_FAST  = 2'd2
  } pgc_policy_e;
endpackage

// File: rtl/pgc_sync.sv
`timescale 1ns/1ps
module pgc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pgc_lock_timer.sv
`timescale 1ns/1ps
module pgc_lock_timer #(
  parameter int LT_W     = 4,
  parameter int PRESCALE = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            load_i,
  input  logic [LT_W-1:0] steps_i,
  input  logic            dec_i,
  output logic            expired_o
);
  localparam int PS_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int CNT_W = LT_W + PS_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(steps_i) * CNT_W'(PRESCALE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clear_i)                  cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val;
    else if (dec_i && (cnt_q != '0))   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pgc_fsm.sv
`timescale 1ns/1ps
module pgc_fsm
  import pgc_pkg::*;
#(
  parameter int LT_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enable_i,
  input  logic            startup_done_i,
  input  logic            lock_sync_i,
  input  logic [LT_W-1:0] lock_steps_i,
  input  logic            fast_wake_i,
  input  logic            lock_bypass_i,
  input  logic            timer_expired_i,
  output logic            timer_clear_o,
  output logic            timer_load_o,
  output logic            timer_dec_o,
  output logic [LT_W-1:0] steps_o,
  output logic            gate_en_o,
  output logic            lock_flag_o,
  output pgc_state_e      state_o,
  output pgc_policy_e     policy_o,
  output logic            bypass_o,
  output logic            acq_o
);
  pgc_state_e  state_q, state_d;
  pgc_policy_e policy_q;
  logic [LT_W-1:0] steps_q;
  logic bypass_q, acq_q, acq_d, lock_q, lock_d, gate_q, gate_d;
  logic load, dec;

  // configuration capture: only on the switch-on edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      policy_q <= POL_LOCK;
      steps_q  <= '0;
      bypass_q <= 1'b0;
    end else if ((state_q == PGC_OFF) && enable_i) begin
      if (fast_wake_i)             policy_q <= POL_FAST;
      else if (lock_steps_i != '0) policy_q <= POL_TIMER;
      else                         policy_q <= POL_LOCK;
      steps_q  <= lock_steps_i;
      bypass_q <= lock_bypass_i;
    end
  end

  always_comb begin
    state_d = state_q;
    lock_d  = 1'b0;
    acq_d   = acq_q;
    load    = 1'b0;
    dec     = 1'b0;
    unique case (state_q)
      PGC_OFF: begin
        acq_d = 1'b0;
        if (enable_i) state_d = PGC_STARTUP;
      end
      PGC_STARTUP: begin
        if (startup_done_i) begin
          if (policy_q == POL_FAST) begin
            state_d = PGC_RUNNING;
            lock_d  = lock_sync_i;
            acq_d   = lock_sync_i;
          end else begin
            state_d = PGC_QUALIFY;
            load    = (policy_q == POL_TIMER);
          end
        end
      end
      PGC_QUALIFY: begin
        if (policy_q == POL_TIMER) begin
          dec = 1'b1;
          if (timer_expired_i) begin
            state_d = PGC_RUNNING;
            lock_d  = 1'b1;
            acq_d   = 1'b1;
          end
        end else if (lock_sync_i) begin
          state_d = PGC_RUNNING;
          lock_d  = 1'b1;
          acq_d   = 1'b1;
        end
      end
      PGC_RUNNING: begin
        lock_d = lock_sync_i;
        acq_d  = acq_q | lock_sync_i;
      end
      default: state_d = PGC_OFF;
    endcase
    if (!enable_i) begin
      state_d = PGC_OFF;
      lock_d  = 1'b0;
      acq_d   = 1'b0;
      load    = 1'b0;
      dec     = 1'b0;
    end
    gate_d = (state_d == PGC_RUNNING) && (bypass_q || !acq_d || lock_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PGC_OFF;
      lock_q  <= 1'b0;
      acq_q   <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lock_q  <= lock_d;
      acq_q   <= acq_d;
      gate_q  <= gate_d;
    end
  end

  assign timer_clear_o = !enable_i;
  assign timer_load_o  = load;
  assign timer_dec_o   = dec;
  assign steps_o       = steps_q;
  assign gate_en_o     = gate_q;
  assign lock_flag_o   = lock_q;
  assign state_o       = state_q;
  assign policy_o      = policy_q;
  assign bypass_o      = bypass_q;
  assign acq_o         = acq_q;
endmodule

// File: rtl/pll_gate_ctrl.sv
`timescale 1ns/1ps
module pll_gate_ctrl
  import pgc_pkg::*;
#(
  parameter int LT_W        = 4,
  parameter int PRESCALE    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enable_i,
  input  logic            pll_lock_i,
  input  logic            startup_done_i,
  input  logic [LT_W-1:0] lock_steps_i,
  input  logic            fast_wake_i,
  input  logic            lock_bypass_i,
  output logic            gate_en_o,
  output logic            lock_flag_o
);
  logic            lock_sync;
  logic            tmr_clear, tmr_load, tmr_dec, tmr_expired;
  logic [LT_W-1:0] steps;
  pgc_state_e      state;
  pgc_policy_e     policy;
  logic            bypass, acq;

  pgc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pll_lock_i),
    .q_o   (lock_sync)
  );

  pgc_lock_timer #(.LT_W(LT_W), .PRESCALE(PRESCALE)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (tmr_clear),
    .load_i   (tmr_load),
    .steps_i  (steps),
    .dec_i    (tmr_dec),
    .expired_o(tmr_expired)
  );

  pgc_fsm #(.LT_W(LT_W)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .enable_i       (enable_i),
    .startup_done_i (startup_done_i),
    .lock_sync_i    (lock_sync),
    .lock_steps_i   (lock_steps_i),
    .fast_wake_i    (fast_wake_i),
    .lock_bypass_i  (lock_bypass_i),
    .timer_expired_i(tmr_expired),
    .timer_clear_o  (tmr_clear),
    .timer_load_o   (tmr_load),
    .timer_dec_o    (tmr_dec),
    .steps_o        (steps),
    .gate_en_o      (gate_en_o),
    .lock_flag_o    (lock_flag_o),
    .state_o        (state),
    .policy_o       (policy),
    .bypass_o       (bypass),
    .acq_o          (acq)
  );
endmodule

// File: rtl/pgc_checker.sv
`timescale 1ns/1ps
module pgc_checker
  import pgc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        enable_i,
  input logic        gate_en_o,
  input logic        lock_flag_o,
  input logic        lock_sync,
  input pgc_state_e  state,
  input pgc_policy_e policy,
  input logic        bypass,
  input logic        acq
);
  a_r1_gate_only_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_en_o |-> (state == PGC_RUNNING));

  a_r2_disable_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!gate_en_o && !lock_flag_o));

  a_r3_startup_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == PGC_STARTUP) |-> (!gate_en_o && !lock_flag_o));

  a_r6_timer_no_early_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state == PGC_QUALIFY) && (policy == POL_TIMER)) |-> !lock_flag_o);

  a_r7_lock_loss_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_en_o && !bypass && acq && enable_i && !lock_sync) |=> !gate_en_o);

  a_r8_bypass_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_en_o && bypass && enable_i) |=> gate_en_o);

  a_r10_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state != PGC_OFF) && enable_i) |=> ($stable(policy) && $stable(bypass)));
endmodule

bind pll_gate_ctrl pgc_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .gate_en_o  (gate_en_o),
  .lock_flag_o(lock_flag_o),
  .lock_sync  (lock_sync),
  .state      (state),
  .policy     (policy),
  .bypass     (bypass),
  .acq        (acq)
);

// File: tb/pll_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module pll_gate_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, raw_lock = 1'b0, su_done = 1'b0;
  logic [3:0] steps = 4'd0;
  logic       fast = 1'b0, byp = 1'b0;
  logic       gate, lockf;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  pll_gate_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .pll_lock_i(raw_lock),
    .startup_done_i(su_done), .lock_steps_i(steps), .fast_wake_i(fast),
    .lock_bypass_i(byp), .gate_en_o(gate), .lock_flag_o(lockf)
  );

  typedef struct packed {
    logic [3:0] lt;
    logic       w;
    logic       b;
    logic       lk;
    logic [8:0] lat;
    logic       lf;
  } vec_t;

  // lt, fast, bypass, raw lock, edges after startup sample, lock flag at opening
  localparam vec_t VECS [6] = '{
    '{4'd0,  1'b0, 1'b0, 1'b1, 9'd1,   1'b1},
    '{4'd3,  1'b0, 1'b0, 1'b1, 9'd49,  1'b1},
    '{4'd1,  1'b0, 1'b1, 1'b1, 9'd17,  1'b1},
    '{4'd5,  1'b1, 1'b0, 1'b1, 9'd0,   1'b1},
    '{4'd0,  1'b1, 1'b1, 1'b0, 9'd0,   1'b0},
    '{4'd15, 1'b0, 1'b0, 1'b0, 9'd241, 1'b1}
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_off();
    enable = 1'b0; su_done = 1'b0;
    edges(3);
  endtask

  // returns at the negedge after the edge that samples startup_done high
  task automatic launch(input logic [3:0] lt, input logic w, input logic b);
    enable = 1'b1; steps = lt; fast = w; byp = b; su_done = 1'b0;
    edges(1);
    su_done = 1'b1;
    edges(1);
  endtask

  task automatic expect_open(input string req, input int lat, input logic lf);
    if (lat > 0) begin
      chk(req, "gate closed at start", gate, 1'b0);
      edges(lat - 1);
      chk(req, "gate closed one edge early", gate, 1'b0);
      edges(1);
    end
    chk(req, "gate open", gate, 1'b1);
    chk(req, "lock flag at opening", lockf, lf);
  endtask

  initial begin
    edges(2);
    chk("R1", "reset gate", gate, 1'b0);
    chk("R1", "reset lock", lockf, 1'b0);
    rst_n = 1'b1;
    edges(2);
    chk("R1", "idle gate", gate, 1'b0);

    // policy table walk
    foreach (VECS[i]) begin
      string tag;
      tag = VECS[i].w ? "R4" : ((VECS[i].lt == 4'd0) ? "R5" : "R6");
      go_off();
      raw_lock = VECS[i].lk;
      edges(3);
      launch(VECS[i].lt, VECS[i].w, VECS[i].b);
      expect_open(tag, int'(VECS[i].lat), VECS[i].lf);
    end

    // R3: start-up wait holds the gate even when lock is present
    go_off();
    raw_lock = 1'b1;
    edges(3);
    enable = 1'b1; fast = 1'b1; byp = 1'b0; steps = 4'd0; su_done = 1'b0;
    edges(10);
    chk("R3", "gate during start-up", gate, 1'b0);
    chk("R3", "lock during start-up", lockf, 1'b0);
    su_done = 1'b1;
    edges(1);
    chk("R4", "gate at start-up end", gate, 1'b1);

    // R7: lock loss and recovery with bypass off
    raw_lock = 1'b0;
    edges(2);
    chk("R7", "gate before sync delay", gate, 1'b1);
    edges(1);
    chk("R7", "gate after lock loss", gate, 1'b0);
    chk("R7", "lock flag after loss", lockf, 1'b0);
    raw_lock = 1'b1;
    edges(3);
    chk("R7", "gate after relock", gate, 1'b1);
    chk("R7", "lock flag after relock", lockf, 1'b1);

    // R2: disable closes on the next edge
    enable = 1'b0;
    edges(1);
    chk("R2", "gate after disable", gate, 1'b0);
    chk("R2", "lock after disable", lockf, 1'b0);

    // R5: late lock while qualifying
    go_off();
    raw_lock = 1'b0;
    edges(3);
    launch(4'd0, 1'b0, 1'b0);
    edges(20);
    chk("R5", "gate without lock", gate, 1'b0);
    raw_lock = 1'b1;
    edges(2);
    chk("R5", "gate two edges after lock", gate, 1'b0);
    edges(1);
    chk("R5", "gate three edges after lock", gate, 1'b1);
    chk("R5", "lock flag with gate", lockf, 1'b1);

    // R10: config changes while running have no effect
    byp = 1'b1; fast = 1'b1; steps = 4'd7;
    raw_lock = 1'b0;
    edges(3);
    chk("R10", "captured bypass off still closes", gate, 1'b0);
    raw_lock = 1'b1;
    edges(3);

    // R8: bypass keeps the gate open
    go_off();
    launch(4'd0, 1'b0, 1'b1);
    expect_open("R8", 1, 1'b1);
    raw_lock = 1'b0;
    edges(3);
    chk("R8", "gate with lock lost", gate, 1'b1);
    chk("R8", "lock flag tracks loss", lockf, 1'b0);
    edges(10);
    chk("R8", "gate still open", gate, 1'b1);

    // R9: fast mode before and after first acquisition
    go_off();
    raw_lock = 1'b0;
    edges(3);
    launch(4'd0, 1'b1, 1'b0);
    chk("R9", "gate at fast open", gate, 1'b1);
    edges(20);
    chk("R9", "gate before acquisition", gate, 1'b1);
    chk("R9", "lock before acquisition", lockf, 1'b0);
    raw_lock = 1'b1;
    edges(3);
    chk("R9", "lock on acquisition", lockf, 1'b1);
    raw_lock = 1'b0;
    edges(3);
    chk("R9", "gate closes after acquisition", gate, 1'b0);

    // R10: lock-time change during qualification is ignored
    go_off();
    raw_lock = 1'b1;
    edges(3);
    enable = 1'b1; steps = 4'd2; fast = 1'b0; byp = 1'b0; su_done = 1'b0;
    edges(1);
    steps = 4'd0; su_done = 1'b1;
    edges(1);
    expect_open("R10", 33, 1'b1);

    // R2: timer restarts in full after an interrupted count
    go_off();
    launch(4'd2, 1'b0, 1'b0);
    edges(10);
    enable = 1'b0;
    edges(1);
    chk("R2", "gate off mid-count", gate, 1'b0);
    launch(4'd2, 1'b0, 1'b0);
    expect_open("R2", 33, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule